// File: doc/BRIEF.md
# Stop Mode Wake Controller

This block sequences a microcontroller's deepest power-saving state. When the CPU issues a stop request, the controller first confirms that the on-chip bus controller peripheral reports that it is asleep. If it is not, the request is turned down with a one-cycle status pulse and nothing else changes. If it is asleep, the controller gates off the oscillator enable. It also freezes the timer and the serial interface, disables the converter, holds the watchdog in reset, write-protects the nonvolatile memory and holds the PWM outputs at their present levels. While stopped it keeps the interrupt mask cleared, and on entry it pulses a clear of the slow-clock bit.

Four wake sources end the stop state: the bus peripheral interrupt, the wired-OR port interrupt, the external interrupt pin and a reset request. On any of them the oscillator is enabled again and the CPU stays held for a settle delay. A static strap selects a delay of 16 or 4064 cycles. The controller then releases the CPU for one cycle with the vector address to fetch: the interrupt pair base for an interrupt wake, or the reset pair base for a reset wake. An interrupt wake also permits stacking in that cycle, and not before. Reset outranks interrupts, and a reset that arrives during the settle delay starts the delay again. The block carries no data stream, so every pin is a plain level or pulse with no valid/ready handshake. The clock is assumed to be a free-running always-on sampling clock, separate from the gated oscillator.

Top module: `stop_wake_ctrl`

## Requirements
- R1: After reset, osc_en=1, cpu_hold=0, cpu_release=0, stack_go=0, stop_refused=0, slow_mode_clr=0, irq_mask_clr=0, all six peripheral controls are 0, and vec_addr=14'h3FFE.
- R2: A stop_req sampled in the run state sets cpu_hold the next cycle (the check cycle). If can_asleep is 1 at the following edge, then from the cycle after it osc_en=0, irq_mask_clr=1 and tmr_freeze, sci_freeze, adc_disable, wdog_reset, nvm_wprot and pwm_hold are all 1.
- R3: If can_asleep is 0 at the end of the check cycle, stop_refused is 1 for exactly one cycle, cpu_hold returns to 0, osc_en stays 1 and all peripheral controls stay 0.
- R4: slow_mode_clr is a one-cycle pulse in the first stopped cycle only.
- R5: While stopped and no wake input is active, osc_en stays 0 and the block stays stopped.
- R6: After a wake, osc_en is 1 from the next cycle, and cpu_hold stays 1 for exactly 16 cycles when long_settle=0 or 4064 cycles when long_settle=1. Then cpu_release is 1 for one cycle, with cpu_hold=0 and all peripheral controls 0.
- R7: An interrupt wake (wake_can, wake_port or wake_irq) gives vec_addr=14'h3FFA and stack_go=1 in the release cycle. A reset wake (wake_reset) gives vec_addr=14'h3FFE and stack_go=0.
- R8: When wake_reset and an interrupt wake are active in the same stopped cycle, the reset vector is chosen.
- R9: A wake_reset during the settle delay restarts the full delay from the cycle after it and selects the reset vector.
- R10: Interrupt wake inputs during the settle delay have no effect on its length or on the vector.
- R11: In the run state the wake inputs have no effect (osc_en=1, cpu_hold=0, cpu_release=0). A stop_req while already stopped has no effect: osc_en stays 0 and no second slow_mode_clr pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on sampling clock |
| rst_n | input | 1 | Active-low block reset |
| stop_req | input | 1 | Stop request pulse from the CPU |
| can_asleep | input | 1 | Bus controller peripheral reports sleep |
| wake_can | input | 1 | Bus peripheral interrupt wake |
| wake_port | input | 1 | Wired-OR port interrupt wake |
| wake_irq | input | 1 | External interrupt pin wake |
| wake_reset | input | 1 | Reset request wake (pin or power-on) |
| long_settle | input | 1 | Static strap: 1 selects 4064-cycle settle, 0 selects 16 |
| osc_en | output | 1 | Oscillator enable |
| cpu_hold | output | 1 | Holds the CPU |
| cpu_release | output | 1 | One-cycle CPU release strobe |
| stack_go | output | 1 | Permits interrupt stacking (release cycle only) |
| vec_addr | output | 14 | Vector pair base address to fetch |
| stop_refused | output | 1 | One-cycle pulse: stop turned down |
| slow_mode_clr | output | 1 | One-cycle clear of the slow-clock bit |
| irq_mask_clr | output | 1 | Holds the interrupt mask cleared |
| tmr_freeze | output | 1 | Timer halt |
| sci_freeze | output | 1 | Serial interface halt |
| adc_disable | output | 1 | Converter disable |
| wdog_reset | output | 1 | Watchdog held in reset |
| nvm_wprot | output | 1 | Nonvolatile memory write protect |
| pwm_hold | output | 1 | PWM outputs hold current level |

## Verification
A wrong state register shows at the ports at once. A stuck or skipped check state shows as a missing or extra cycle of cpu_hold before osc_en falls. A lost stopped state shows as osc_en returning high with no wake input. A settle counter with a wrong limit or a missed restart is seen only at the release strobe, which comes up to 4063 cycles early or late. The bench therefore counts every held cycle from the wake to the release. A wrong vector flag stays hidden until the release cycle, where vec_addr and stack_go expose it.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_CHECK   = 3'd1,
    ST_STOPPED = 3'd2,
    ST_SETTLE  = 3'd3,
    ST_RESUME  = 3'd4
  } swc_state_e;

  localparam int unsigned NUM_PERIPH = 6;

  typedef struct packed {
    logic tmr_freeze;
    logic sci_freeze;
    logic adc_disable;
    logic wdog_reset;
    logic nvm_wprot;
    logic pwm_hold;
  } periph_ctl_t;
endpackage

// File: rtl/swc_settle_cnt.sv
module swc_settle_cnt #(
  parameter int unsigned SHORT_CYCLES = 16,
  parameter int unsigned LONG_CYCLES  = 4064
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  input  logic long_sel,
  output logic done
);
  localparam int unsigned CW = $clog2(LONG_CYCLES);
  localparam logic [CW-1:0] LIM_SHORT = CW'(SHORT_CYCLES - 1);
  localparam logic [CW-1:0] LIM_LONG  = CW'(LONG_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  assign limit = long_sel ? LIM_LONG : LIM_SHORT;
  assign done  = run && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (run && !done) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/swc_fsm.sv
module swc_fsm
  import swc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_req,
  input  logic       can_asleep,
  input  logic       irq_any,
  input  logic       wake_reset,
  input  logic       settle_done,
  output swc_state_e state_q,
  output logic       hold_nxt,
  output logic       cnt_clear,
  output logic       cnt_run,
  output logic       vec_rst_q,
  output logic       refused_q,
  output logic       slow_clr_q
);
  swc_state_e state_d;
  logic       vec_rst_d;
  logic       wake_any;

  assign wake_any  = irq_any || wake_reset;
  assign cnt_run   = (state_q == ST_SETTLE);
  assign cnt_clear = ((state_q == ST_STOPPED) && wake_any) ||
                     ((state_q == ST_SETTLE) && wake_reset);
  assign hold_nxt  = (state_d == ST_STOPPED) || (state_d == ST_SETTLE);

  always_comb begin
    state_d   = state_q;
    vec_rst_d = vec_rst_q;
    unique case (state_q)
      ST_RUN: begin
        if (stop_req) state_d = ST_CHECK;
      end
      ST_CHECK: begin
        state_d = can_asleep ? ST_STOPPED : ST_RUN;
      end
      ST_STOPPED: begin
        if (wake_any) begin
          state_d   = ST_SETTLE;
          vec_rst_d = wake_reset;
        end
      end
      ST_SETTLE: begin
        if (wake_reset) begin
          vec_rst_d = 1'b1;
        end else if (settle_done) begin
          state_d = ST_RESUME;
        end
      end
      ST_RESUME: begin
        state_d = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_RUN;
      vec_rst_q  <= 1'b1;
      refused_q  <= 1'b0;
      slow_clr_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      vec_rst_q  <= vec_rst_d;
      refused_q  <= (state_q == ST_CHECK) && !can_asleep;
      slow_clr_q <= (state_q == ST_CHECK) && can_asleep;
    end
  end
endmodule

// File: rtl/swc_periph_gate.sv
module swc_periph_gate
  import swc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hold_nxt,
  output periph_ctl_t ctl_q
);
  logic [NUM_PERIPH-1:0] bits_q;

  for (genvar g = 0; g < NUM_PERIPH; g++) begin : g_ctl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bits_q[g] <= 1'b0;
      else        bits_q[g] <= hold_nxt;
    end
  end

  assign ctl_q = periph_ctl_t'(bits_q);
endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
  import swc_pkg::*;
#(
  parameter int unsigned SHORT_CYCLES = 16,
  parameter int unsigned LONG_CYCLES  = 4064,
  parameter int unsigned VEC_W        = 14,
  parameter logic [VEC_W-1:0] IRQ_VEC = 14'h3FFA,
  parameter logic [VEC_W-1:0] RST_VEC = 14'h3FFE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_req,
  input  logic             can_asleep,
  input  logic             wake_can,
  input  logic             wake_port,
  input  logic             wake_irq,
  input  logic             wake_reset,
  input  logic             long_settle,
  output logic             osc_en,
  output logic             cpu_hold,
  output logic             cpu_release,
  output logic             stack_go,
  output logic [VEC_W-1:0] vec_addr,
  output logic             stop_refused,
  output logic             slow_mode_clr,
  output logic             irq_mask_clr,
  output logic             tmr_freeze,
  output logic             sci_freeze,
  output logic             adc_disable,
  output logic             wdog_reset,
  output logic             nvm_wprot,
  output logic             pwm_hold
);
  swc_state_e  state_q;
  logic        hold_nxt, cnt_clear, cnt_run, settle_done, vec_rst_q;
  periph_ctl_t ctl_q;

  swc_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_req   (stop_req),
    .can_asleep (can_asleep),
    .irq_any    (wake_can || wake_port || wake_irq),
    .wake_reset (wake_reset),
    .settle_done(settle_done),
    .state_q    (state_q),
    .hold_nxt   (hold_nxt),
    .cnt_clear  (cnt_clear),
    .cnt_run    (cnt_run),
    .vec_rst_q  (vec_rst_q),
    .refused_q  (stop_refused),
    .slow_clr_q (slow_mode_clr)
  );

  swc_settle_cnt #(
    .SHORT_CYCLES(SHORT_CYCLES),
    .LONG_CYCLES (LONG_CYCLES)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (cnt_clear),
    .run     (cnt_run),
    .long_sel(long_settle),
    .done    (settle_done)
  );

  swc_periph_gate u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold_nxt(hold_nxt),
    .ctl_q   (ctl_q)
  );

  assign osc_en       = (state_q != ST_STOPPED);
  assign cpu_hold     = (state_q == ST_CHECK) || (state_q == ST_STOPPED) ||
                        (state_q == ST_SETTLE);
  assign cpu_release  = (state_q == ST_RESUME);
  assign stack_go     = (state_q == ST_RESUME) && !vec_rst_q;
  assign vec_addr     = vec_rst_q ? RST_VEC : IRQ_VEC;
  assign irq_mask_clr = (state_q == ST_STOPPED) || (state_q == ST_SETTLE);

  assign tmr_freeze  = ctl_q.tmr_freeze;
  assign sci_freeze  = ctl_q.sci_freeze;
  assign adc_disable = ctl_q.adc_disable;
  assign wdog_reset  = ctl_q.wdog_reset;
  assign nvm_wprot   = ctl_q.nvm_wprot;
  assign pwm_hold    = ctl_q.pwm_hold;
endmodule

// File: rtl/swc_chk.sv
module swc_chk #(
  parameter int unsigned VEC_W = 14,
  parameter logic [VEC_W-1:0] IRQ_VEC = 14'h3FFA
) (
  input logic             clk,
  input logic             rst_n,
  input logic             can_asleep,
  input logic             wake_can,
  input logic             wake_port,
  input logic             wake_irq,
  input logic             wake_reset,
  input logic             osc_en,
  input logic             cpu_hold,
  input logic             cpu_release,
  input logic             stack_go,
  input logic [VEC_W-1:0] vec_addr,
  input logic             stop_refused,
  input logic             tmr_freeze,
  input logic             sci_freeze,
  input logic             adc_disable,
  input logic             wdog_reset,
  input logic             nvm_wprot,
  input logic             pwm_hold
);
  logic all_held;
  assign all_held = tmr_freeze && sci_freeze && adc_disable &&
                    wdog_reset && nvm_wprot && pwm_hold;

  // R2
  osc_off_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> (all_held && cpu_hold));

  // R2
  osc_fall_needs_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osc_en) |-> ($past(can_asleep) && $past(cpu_hold)));

  // R3
  refuse_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_refused |-> (osc_en && !tmr_freeze && !cpu_hold));

  // R3
  refuse_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_refused |=> !stop_refused);

  // R5
  stay_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en && !wake_can && !wake_port && !wake_irq && !wake_reset) |=> !osc_en);

  // R6
  release_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_release |=> (!cpu_release && !cpu_hold));

  // R7
  stack_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stack_go |-> (cpu_release && vec_addr == IRQ_VEC));
endmodule

bind stop_wake_ctrl swc_chk #(.VEC_W(VEC_W), .IRQ_VEC(IRQ_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .can_asleep(can_asleep),
  .wake_can(wake_can), .wake_port(wake_port), .wake_irq(wake_irq),
  .wake_reset(wake_reset), .osc_en(osc_en), .cpu_hold(cpu_hold),
  .cpu_release(cpu_release), .stack_go(stack_go), .vec_addr(vec_addr),
  .stop_refused(stop_refused), .tmr_freeze(tmr_freeze),
  .sci_freeze(sci_freeze), .adc_disable(adc_disable),
  .wdog_reset(wdog_reset), .nvm_wprot(nvm_wprot), .pwm_hold(pwm_hold)
);

// File: tb/stop_wake_ctrl_tb.sv
module stop_wake_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req = 0, can_asleep = 0, wake_can = 0, wake_port = 0;
  logic wake_irq = 0, wake_reset = 0, long_settle = 0;
  logic osc_en, cpu_hold, cpu_release, stack_go, stop_refused;
  logic slow_mode_clr, irq_mask_clr;
  logic tmr_freeze, sci_freeze, adc_disable, wdog_reset, nvm_wprot, pwm_hold;
  logic [13:0] vec_addr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  stop_wake_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .can_asleep(can_asleep),
    .wake_can(wake_can), .wake_port(wake_port), .wake_irq(wake_irq),
    .wake_reset(wake_reset), .long_settle(long_settle), .osc_en(osc_en),
    .cpu_hold(cpu_hold), .cpu_release(cpu_release), .stack_go(stack_go),
    .vec_addr(vec_addr), .stop_refused(stop_refused),
    .slow_mode_clr(slow_mode_clr), .irq_mask_clr(irq_mask_clr),
    .tmr_freeze(tmr_freeze), .sci_freeze(sci_freeze),
    .adc_disable(adc_disable), .wdog_reset(wdog_reset),
    .nvm_wprot(nvm_wprot), .pwm_hold(pwm_hold)
  );

  function automatic int settle_len(bit lng);
    return lng ? 4064 : 16;
  endfunction

  function automatic int exp_vec(bit rst_wake);
    return rst_wake ? 'h3FFE : 'h3FFA;
  endfunction

  function automatic int periph();
    return {tmr_freeze, sci_freeze, adc_disable, wdog_reset, nvm_wprot, pwm_hold};
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_stop(bit asleep);
    stop_req = 1; can_asleep = asleep;
    tick();
    stop_req = 0;
    chk(cpu_hold && osc_en, "R2 check cycle hold", {cpu_hold, osc_en}, 2'b11);
    tick();
    if (asleep) begin
      chk(!osc_en, "R2 osc off", osc_en, 0);
      chk(periph() == 'h3F, "R2 periph held", periph(), 'h3F);
      chk(irq_mask_clr, "R2 mask clear", irq_mask_clr, 1);
      chk(slow_mode_clr, "R4 slow clear pulse", slow_mode_clr, 1);
      tick();
      chk(!slow_mode_clr, "R4 slow clear ends", slow_mode_clr, 0);
    end else begin
      chk(stop_refused, "R3 refuse pulse", stop_refused, 1);
      chk(osc_en && !cpu_hold && periph() == 0, "R3 refused unchanged",
          {osc_en, cpu_hold, periph()}, 'h100);
      tick();
      chk(!stop_refused, "R3 refuse one cycle", stop_refused, 0);
    end
  endtask

  // src: 0 can, 1 port, 2 irq pin, 3 reset, 4 reset+irq; rst_k > 0 injects reset
  // during settle; irq_j > 0 injects an interrupt during settle.
  task automatic do_wake(int src, int rst_k, int irq_j);
    int n = 0;
    bit rst_wake;
    rst_wake = (src >= 3) || (rst_k > 0);
    wake_can = (src == 0); wake_port = (src == 1);
    wake_irq = (src == 2) || (src == 4); wake_reset = (src >= 3);
    tick();
    wake_can = 0; wake_port = 0; wake_irq = 0; wake_reset = 0;
    chk(osc_en, "R6 osc back on", osc_en, 1);
    while (cpu_hold && n < 10000) begin
      n++;
      if (n == rst_k) wake_reset = 1;
      if (n == irq_j) wake_port = 1;
      tick();
      wake_reset = 0; wake_port = 0;
    end
    chk(n == settle_len(long_settle) + rst_k, "R6 R9 R10 settle length", n,
        settle_len(long_settle) + rst_k);
    chk(cpu_release && periph() == 0, "R6 release", {cpu_release, periph()}, 'h40);
    chk(vec_addr == exp_vec(rst_wake), "R7 R8 R9 vector", vec_addr, exp_vec(rst_wake));
    chk(stack_go == !rst_wake, "R7 stacking", stack_go, !rst_wake);
    tick();
    chk(!cpu_release && !cpu_hold, "R6 release one cycle", {cpu_release, cpu_hold}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5A17);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(osc_en && !cpu_hold && !cpu_release && !stack_go && !stop_refused &&
        !slow_mode_clr && !irq_mask_clr && periph() == 0, "R1 reset outputs",
        {osc_en, cpu_hold, periph()}, 'h100);
    chk(vec_addr == 'h3FFE, "R1 reset vector", vec_addr, 'h3FFE);
    rst_n = 1;
    tick();

    // R11 wake inputs in run state
    wake_irq = 1; wake_reset = 1;
    tick();
    wake_irq = 0; wake_reset = 0;
    chk(osc_en && !cpu_hold && !cpu_release, "R11 run ignores wake",
        {osc_en, cpu_hold, cpu_release}, 'b100);

    // directed: refused, then each source, priority, restart, ignored irq
    do_stop(0);
    do_stop(1);
    repeat (5) begin
      tick();
      chk(!osc_en, "R5 stays stopped", osc_en, 1'b0);
    end
    stop_req = 1;
    tick();
    stop_req = 0;
    chk(!osc_en && !slow_mode_clr, "R11 stop while stopped ignored",
        {osc_en, slow_mode_clr}, 0);
    tick();
    chk(!osc_en && !slow_mode_clr, "R11 still stopped", {osc_en, slow_mode_clr}, 0);
    do_wake(2, 0, 0);
    do_stop(1); do_wake(3, 0, 0);
    do_stop(1); do_wake(4, 0, 0);          // R8
    do_stop(1); do_wake(0, 7, 0);          // R9
    do_stop(1); do_wake(1, 0, 5);          // R10
    long_settle = 1;
    do_stop(1); do_wake(2, 0, 0);
    do_stop(1); do_wake(1, 100, 0);        // R9 long
    long_settle = 0;

    // constrained random
    for (int i = 0; i < 30; i++) begin
      bit asleep;
      int src, k, j;
      asleep = ($urandom % 4) != 0;
      long_settle = (i % 8 == 0);
      src = $urandom % 5;
      k = (($urandom % 3) == 0) ? 1 + ($urandom % 12) : 0;
      j = (($urandom % 3) == 0) ? 1 + ($urandom % 12) : 0;
      do_stop(asleep);
      if (asleep) begin
        repeat ($urandom % 6) begin
          tick();
          chk(!osc_en, "R5 random stopped", osc_en, 0);
        end
        do_wake(src, k, j);
      end
      repeat ($urandom % 3) tick();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule